// File: doc/BRIEF.md
# Shadow Sector Access Guard

This block sits on an AHB-style bus between the masters and a flash slave and rules on every transfer whose address phase it accepts. The shadow region is sixteen kilobytes split into four equal sectors. For each sector it keeps two settings. The first says whether user-mode software may touch the sector or only supervisor code. The second says whether the sector may be fetched as instructions or only read and written as data. Two global level inputs come from the main-array protection logic. One forbids user access and one forbids instruction fetch, and both apply to every address. A transfer goes ahead only if no check refuses it.

After reset the guard holds the bus stalled. It reads one configuration word from a fixed location near the top of the shadow region and stores both 8-bit control fields from that word. Only then does it open the bus. An erased word reads as all ones, which makes every sector supervisor-only but leaves instruction fetch allowed. A refused transfer is never shown to the flash. The guard answers it with the two-cycle AHB error response. A permitted transfer is forwarded, and its data phase reflects the flash's own ready and response.

Address, write and data lines run straight from the masters to the flash. Only the transfer type and the slave-side HREADY go through the guard.

Top module: `flash_shadow_guard`

## Requirements
- R1: From reset until the configuration read returns, cfg_rd_req is 1 and cfg_rd_addr is 0x00FF_FE00, s_hready is 0 and f_htrans is IDLE (2'b00), so no transfer is accepted or forwarded.
- R2: On the cycle cfg_rd_valid is 1 during the load, bits [7:0] of cfg_rd_data become the supervisor field and bits [15:8] become the fetch field. The next cycle the bus opens. An all-ones word makes every shadow sector supervisor-only with fetch allowed.
- R3: The shadow region is 0x00FF_C000 to 0x00FF_FFFF. The sector index is address bits [13:12], and sector n is controlled by bit 4+n of each field.
- R4: A user access (s_hprot[1]=0) to a shadow sector whose supervisor bit is 1 is refused. A bit value of 0 permits both privilege levels.
- R5: An instruction fetch (s_hprot[0]=0) from a shadow sector whose fetch bit is 0 is refused. A bit value of 1 permits both fetch and data.
- R6: glb_user_deny=1 refuses every user access, and glb_fetch_deny=1 refuses every fetch, at any address.
- R7: Addresses outside the shadow region ignore the sector fields, and only R6 applies to them.
- R8: In the address phase of a refused transfer, f_htrans is IDLE, so the flash never sees it.
- R9: The cycle after a refused transfer is accepted has s_hready=0 and s_hresp=1. The cycle after that has s_hready=1 and s_hresp=1.
- R10: A permitted transfer drives f_htrans equal to s_htrans. In its data phase, s_hready and s_hresp follow f_hreadyout and f_hresp.
- R11: A transfer presented in the second error cycle is accepted and judged like any other. A refused one starts a new error response, and a permitted one is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_haddr | input | 32 | Transfer address from the master |
| s_htrans | input | 2 | Transfer type from the master |
| s_hprot | input | 2 | Protection bits: [1] 1 = privileged, [0] 1 = data, 0 = fetch |
| s_hready | output | 1 | Ready returned to the master |
| s_hresp | output | 1 | Response returned to the master, 1 = error |
| f_htrans | output | 2 | Transfer type forwarded to the flash |
| f_hready | output | 1 | Bus ready presented to the flash |
| f_hreadyout | input | 1 | Ready driven by the flash |
| f_hresp | input | 1 | Response driven by the flash |
| glb_user_deny | input | 1 | Global setting: refuse user-mode access |
| glb_fetch_deny | input | 1 | Global setting: refuse instruction fetch |
| cfg_rd_req | output | 1 | Configuration read pending |
| cfg_rd_addr | output | 32 | Address of the configuration word |
| cfg_rd_data | input | 16 | Low half of the configuration word |
| cfg_rd_valid | input | 1 | Configuration data valid |

## Verification
The assertions check, on every cycle, that the load phase keeps the bus stalled and idle. They also check that an accepted transfer that is not forwarded is followed by exactly the two error cycles. Finally, they check that no user access to a supervisor-only sector, and no fetch from a data-only sector or under the global settings, ever reaches the flash. Only the bench's scenarios show the rest. These are that the right bits of the configuration word land in the right sectors, that erased flash gives the stated defaults, and that permitted transfers get the flash's own response. They also cover back-to-back transfers arriving in the second error cycle.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [1:0] {
    RS_PASS = 2'd0,
    RS_ERR1 = 2'd1,
    RS_ERR2 = 2'd2
  } rsp_state_e;

  typedef enum logic {
    LD_FETCH = 1'b0,
    LD_DONE  = 1'b1
  } ld_state_e;

  localparam logic [1:0] HTRANS_IDLE = 2'b00;
endpackage

// File: rtl/fsg_cfg_loader.sv
module fsg_cfg_loader
  import fsg_pkg::*;
#(
  parameter int               ADDR_W      = 32,
  parameter int               FIELD_W     = 8,
  parameter logic [ADDR_W-1:0] SHADOW_BASE = 32'h00FF_C000,
  parameter logic [ADDR_W-1:0] CFG_OFS     = 32'h0000_3E00
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic                 cfg_rd_req,
  output logic [ADDR_W-1:0]    cfg_rd_addr,
  input  logic                 cfg_rd_valid,
  input  logic [2*FIELD_W-1:0] cfg_rd_data,
  output logic                 loaded,
  output logic [FIELD_W-1:0]   sup_fld,
  output logic [FIELD_W-1:0]   dat_fld
);
  ld_state_e          state_q, state_d;
  logic               cap_en;
  logic [FIELD_W-1:0] sup_q, dat_q;

  assign cap_en = (state_q == LD_FETCH) && cfg_rd_valid;

  always_comb begin
    state_d = state_q;
    if (cap_en) state_d = LD_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_FETCH;
      sup_q   <= '1;
      dat_q   <= '1;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        sup_q <= cfg_rd_data[FIELD_W-1:0];
        dat_q <= cfg_rd_data[2*FIELD_W-1:FIELD_W];
      end
    end
  end

  assign cfg_rd_req  = (state_q == LD_FETCH);
  assign cfg_rd_addr = SHADOW_BASE + CFG_OFS;
  assign loaded      = (state_q == LD_DONE);
  assign sup_fld     = sup_q;
  assign dat_fld     = dat_q;
endmodule

// File: rtl/fsg_sector_check.sv
module fsg_sector_check #(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] SHADOW_BASE = 32'h00FF_C000,
  parameter int                SECT_LOG2   = 12,
  parameter int                SECT_BITS   = 2,
  parameter int                FIELD_W     = 8,
  parameter int                FIELD_LSB   = 4
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         prot,
  input  logic [FIELD_W-1:0] sup_fld,
  input  logic [FIELD_W-1:0] dat_fld,
  input  logic               glb_user_deny,
  input  logic               glb_fetch_deny,
  output logic               deny
);
  localparam int REG_LOG2 = SECT_LOG2 + SECT_BITS;
  localparam int NSECT    = 1 << SECT_BITS;

  logic                 is_user, is_fetch, in_shadow, glb_deny;
  logic [NSECT-1:0]     sect_deny;
  logic [SECT_BITS-1:0] sect_idx;
  logic                 unused_bits;

  assign is_user   = ~prot[1];
  assign is_fetch  = ~prot[0];
  assign in_shadow = (addr[ADDR_W-1:REG_LOG2] == SHADOW_BASE[ADDR_W-1:REG_LOG2]);
  assign sect_idx  = addr[REG_LOG2-1:SECT_LOG2];

  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    assign sect_deny[s] = (is_user  &  sup_fld[FIELD_LSB+s]) |
                          (is_fetch & ~dat_fld[FIELD_LSB+s]);
  end

  assign glb_deny = (is_user & glb_user_deny) | (is_fetch & glb_fetch_deny);
  assign deny     = glb_deny | (in_shadow & sect_deny[sect_idx]);

  assign unused_bits = ^{addr[SECT_LOG2-1:0], sup_fld[FIELD_LSB-1:0], dat_fld[FIELD_LSB-1:0]};
endmodule

// File: rtl/fsg_err_seq.sv
module fsg_err_seq
  import fsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       loaded,
  input  logic [1:0] s_htrans,
  input  logic       deny,
  input  logic       f_hreadyout,
  input  logic       f_hresp,
  output logic       s_hready,
  output logic       s_hresp,
  output logic [1:0] f_htrans
);
  rsp_state_e state_q, state_d;
  logic       accept, fwd_ok;

  always_comb begin
    if (!loaded)                  s_hready = 1'b0;
    else if (state_q == RS_ERR1)  s_hready = 1'b0;
    else if (state_q == RS_ERR2)  s_hready = 1'b1;
    else                          s_hready = f_hreadyout;
  end

  always_comb begin
    if (state_q == RS_ERR1 || state_q == RS_ERR2) s_hresp = 1'b1;
    else                                          s_hresp = loaded & f_hresp;
  end

  assign accept   = s_hready & s_htrans[1];
  assign fwd_ok   = loaded & (state_q != RS_ERR1) & ~deny;
  assign f_htrans = fwd_ok ? s_htrans : HTRANS_IDLE;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RS_PASS: if (accept && deny) state_d = RS_ERR1;
      RS_ERR1: state_d = RS_ERR2;
      RS_ERR2: state_d = (accept && deny) ? RS_ERR1 : RS_PASS;
      default: state_d = RS_PASS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RS_PASS;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/flash_shadow_guard.sv
module flash_shadow_guard
  import fsg_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] SHADOW_BASE = 32'h00FF_C000,
  parameter logic [ADDR_W-1:0] CFG_OFS     = 32'h0000_3E00,
  parameter int                SECT_LOG2   = 12,
  parameter int                SECT_BITS   = 2,
  parameter int                FIELD_W     = 8,
  parameter int                FIELD_LSB   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    s_haddr,
  input  logic [1:0]           s_htrans,
  input  logic [1:0]           s_hprot,
  output logic                 s_hready,
  output logic                 s_hresp,
  output logic [1:0]           f_htrans,
  output logic                 f_hready,
  input  logic                 f_hreadyout,
  input  logic                 f_hresp,
  input  logic                 glb_user_deny,
  input  logic                 glb_fetch_deny,
  output logic                 cfg_rd_req,
  output logic [ADDR_W-1:0]    cfg_rd_addr,
  input  logic [2*FIELD_W-1:0] cfg_rd_data,
  input  logic                 cfg_rd_valid
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic               loaded, deny;
  logic [FIELD_W-1:0] sup_fld, dat_fld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fsg_cfg_loader #(
    .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .SHADOW_BASE(SHADOW_BASE), .CFG_OFS(CFG_OFS)
  ) u_loader (
    .clk(clk), .rst_n(rst_int_n),
    .cfg_rd_req(cfg_rd_req), .cfg_rd_addr(cfg_rd_addr),
    .cfg_rd_valid(cfg_rd_valid), .cfg_rd_data(cfg_rd_data),
    .loaded(loaded), .sup_fld(sup_fld), .dat_fld(dat_fld)
  );

  fsg_sector_check #(
    .ADDR_W(ADDR_W), .SHADOW_BASE(SHADOW_BASE), .SECT_LOG2(SECT_LOG2),
    .SECT_BITS(SECT_BITS), .FIELD_W(FIELD_W), .FIELD_LSB(FIELD_LSB)
  ) u_check (
    .addr(s_haddr), .prot(s_hprot), .sup_fld(sup_fld), .dat_fld(dat_fld),
    .glb_user_deny(glb_user_deny), .glb_fetch_deny(glb_fetch_deny), .deny(deny)
  );

  fsg_err_seq u_err (
    .clk(clk), .rst_n(rst_int_n), .loaded(loaded), .s_htrans(s_htrans), .deny(deny),
    .f_hreadyout(f_hreadyout), .f_hresp(f_hresp),
    .s_hready(s_hready), .s_hresp(s_hresp), .f_htrans(f_htrans)
  );

  assign f_hready = s_hready;
endmodule

// File: rtl/flash_shadow_guard_chk.sv
module flash_shadow_guard_chk #(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] SHADOW_BASE = 32'h00FF_C000,
  parameter int                SECT_LOG2   = 12,
  parameter int                SECT_BITS   = 2,
  parameter int                FIELD_W     = 8,
  parameter int                FIELD_LSB   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  s_haddr,
  input logic [1:0]         s_htrans,
  input logic [1:0]         s_hprot,
  input logic               s_hready,
  input logic               s_hresp,
  input logic [1:0]         f_htrans,
  input logic               glb_user_deny,
  input logic               glb_fetch_deny,
  input logic               cfg_rd_req,
  input logic [FIELD_W-1:0] sup_fld,
  input logic [FIELD_W-1:0] dat_fld
);
  localparam int REG_LOG2 = SECT_LOG2 + SECT_BITS;

  logic       c_shadow;
  logic [SECT_BITS-1:0] c_sec;
  logic       c_acc;

  assign c_shadow = (s_haddr[ADDR_W-1:REG_LOG2] == SHADOW_BASE[ADDR_W-1:REG_LOG2]);
  assign c_sec    = s_haddr[REG_LOG2-1:SECT_LOG2];
  assign c_acc    = !cfg_rd_req && s_hready && s_htrans[1];

  // R1: load phase stalls the bus
  a_r1_load_stall: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_req |-> (!s_hready && f_htrans == 2'b00));

  // R9: accepted but not forwarded -> first error cycle
  a_r9_err_first: assert property (@(posedge clk) disable iff (!rst_n)
    (c_acc && !f_htrans[1]) |=> (!s_hready && s_hresp));

  // R9: second error cycle
  a_r9_err_second: assert property (@(posedge clk) disable iff (!rst_n)
    (c_acc && !f_htrans[1]) |=> ##1 (s_hready && s_hresp));

  // R4: user access to supervisor-only sector never forwarded
  a_r4_user_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (c_acc && c_shadow && !s_hprot[1] && sup_fld[FIELD_LSB + int'(c_sec)]) |-> !f_htrans[1]);

  // R5: fetch from data-only sector never forwarded
  a_r5_fetch_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (c_acc && c_shadow && !s_hprot[0] && !dat_fld[FIELD_LSB + int'(c_sec)]) |-> !f_htrans[1]);

  // R6: global settings block everywhere
  a_r6_global_block: assert property (@(posedge clk) disable iff (!rst_n)
    (s_htrans[1] && ((!s_hprot[1] && glb_user_deny) || (!s_hprot[0] && glb_fetch_deny)))
      |-> !f_htrans[1]);
endmodule

bind flash_shadow_guard flash_shadow_guard_chk #(
  .ADDR_W(ADDR_W), .SHADOW_BASE(SHADOW_BASE), .SECT_LOG2(SECT_LOG2),
  .SECT_BITS(SECT_BITS), .FIELD_W(FIELD_W), .FIELD_LSB(FIELD_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .s_haddr(s_haddr), .s_htrans(s_htrans), .s_hprot(s_hprot),
  .s_hready(s_hready), .s_hresp(s_hresp), .f_htrans(f_htrans),
  .glb_user_deny(glb_user_deny), .glb_fetch_deny(glb_fetch_deny),
  .cfg_rd_req(cfg_rd_req), .sup_fld(sup_fld), .dat_fld(dat_fld)
);

// File: tb/flash_shadow_guard_bench.sv
`timescale 1ns/1ps
module flash_shadow_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] s_haddr;
  logic [1:0]  s_htrans, s_hprot;
  logic        s_hready, s_hresp;
  logic [1:0]  f_htrans;
  logic        f_hready, f_hreadyout, f_hresp;
  logic        glb_user_deny, glb_fetch_deny;
  logic        cfg_rd_req;
  logic [31:0] cfg_rd_addr;
  logic [15:0] cfg_rd_data;
  logic        cfg_rd_valid;

  int total = 0;
  int bad   = 0;
  logic [7:0] m_sup, m_dat;

  always #2.5 clk = ~clk;

  flash_shadow_guard u_flash_shadow_guard (
    .clk(clk), .rst_n(rst_n), .s_haddr(s_haddr), .s_htrans(s_htrans), .s_hprot(s_hprot),
    .s_hready(s_hready), .s_hresp(s_hresp), .f_htrans(f_htrans), .f_hready(f_hready),
    .f_hreadyout(f_hreadyout), .f_hresp(f_hresp),
    .glb_user_deny(glb_user_deny), .glb_fetch_deny(glb_fetch_deny),
    .cfg_rd_req(cfg_rd_req), .cfg_rd_addr(cfg_rd_addr),
    .cfg_rd_data(cfg_rd_data), .cfg_rd_valid(cfg_rd_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_deny(input logic [31:0] a, input logic [1:0] p,
                                  input logic [7:0] sup, input logic [7:0] dat,
                                  input bit gu, input bit gf);
    bit user, fetch, d;
    int s;
    user  = !p[1];
    fetch = !p[0];
    s     = int'(a[13:12]);
    d     = (user && gu) || (fetch && gf);
    if (a[31:14] == 18'h003FF) d = d || (user && sup[4+s]) || (fetch && !dat[4+s]);
    return d;
  endfunction

  function automatic string req_of(input logic [31:0] a, input logic [1:0] p,
                                   input bit gu, input bit gf);
    if ((!p[1] && gu) || (!p[0] && gf)) return "R6";
    if (a[31:14] != 18'h003FF) return "R7";
    if (!p[1]) return "R4/R3";
    return "R5/R3";
  endfunction

  task automatic do_reset(input logic [15:0] word);
    rst_n = 1'b0;
    s_htrans = 2'b00; cfg_rd_valid = 1'b0; cfg_rd_data = 16'h0;
    repeat (3) @(negedge clk);
    #1 chk(cfg_rd_req && !s_hready, "R1 in reset", {30'd0, cfg_rd_req, s_hready}, 32'h2);
    @(negedge clk);
    rst_n = 1'b1;
    s_htrans = 2'b10; s_haddr = 32'h0000_1000; s_hprot = 2'b11;
    repeat (4) begin
      @(negedge clk);
      #1 chk(!s_hready && f_htrans == 2'b00 && cfg_rd_req, "R1 stall",
             {29'd0, s_hready, f_htrans}, 32'h0);
    end
    chk(cfg_rd_addr == 32'h00FF_FE00, "R1 cfg addr", cfg_rd_addr, 32'h00FF_FE00);
    cfg_rd_valid = 1'b1; cfg_rd_data = word;
    @(negedge clk);
    cfg_rd_valid = 1'b0; s_htrans = 2'b00;
    #1 chk(s_hready && !cfg_rd_req, "R2 bus opens", {30'd0, s_hready, cfg_rd_req}, 32'h2);
    m_sup = word[7:0];
    m_dat = word[15:8];
  endtask

  task automatic xfer(input logic [31:0] a, input logic [1:0] p, input bit gu, input bit gf);
    bit    d;
    string r;
    @(negedge clk);
    glb_user_deny = gu; glb_fetch_deny = gf;
    s_haddr = a; s_hprot = p; s_htrans = 2'b10;
    d = exp_deny(a, p, m_sup, m_dat, gu, gf);
    r = d ? req_of(a, p, gu, gf) : "R10";
    #1 chk(f_htrans == (d ? 2'b00 : 2'b10), {r, " R8 fwd"}, {30'd0, f_htrans}, d ? 32'h0 : 32'h2);
    @(negedge clk);
    s_htrans = 2'b00;
    #1;
    if (d) begin
      chk(!s_hready && s_hresp, {r, " R9 err1"}, {30'd0, s_hready, s_hresp}, 32'h1);
      @(negedge clk);
      #1 chk(s_hready && s_hresp, {r, " R9 err2"}, {30'd0, s_hready, s_hresp}, 32'h3);
    end else begin
      chk(s_hready && !s_hresp, "R10 okay", {30'd0, s_hready, s_hresp}, 32'h2);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    f_hreadyout = 1'b1; f_hresp = 1'b0;
    glb_user_deny = 1'b0; glb_fetch_deny = 1'b0;
    s_haddr = '0; s_hprot = 2'b11; s_htrans = 2'b00;
    for (int k = 0; k < 4; k++) begin
      logic [15:0] w;
      w = (k == 0) ? 16'hFFFF : (k == 1) ? 16'hA050 : 16'($urandom);
      do_reset(w);
      // R2 R3: walk every sector with every privilege/type combination
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 4; p++)
          xfer(32'h00FF_C000 + 32'(s) * 32'h1000 + 32'h20, 2'(p), 1'b0, 1'b0);
      // R7: just outside the region on both sides
      xfer(32'h00FF_BFFC, 2'b00, 1'b0, 1'b0);
      xfer(32'h0100_0000, 2'b00, 1'b0, 1'b0);
      for (int i = 0; i < 60; i++) begin
        logic [31:0] a;
        a = ($urandom % 10 < 7) ? {18'h003FF, 14'($urandom)} : $urandom;
        xfer(a, 2'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 4 == 0));
      end
    end

    // R2: erased word defaults, directed
    do_reset(16'hFFFF);
    xfer(32'h00FF_E000, 2'b01, 1'b0, 1'b0);
    xfer(32'h00FF_E000, 2'b10, 1'b0, 1'b0);

    // R11: refused transfer waiting through the error response
    do_reset(16'hA050);
    @(negedge clk);
    s_haddr = 32'h00FF_C010; s_hprot = 2'b01; s_htrans = 2'b10;
    @(negedge clk);
    #1 chk(!s_hready && s_hresp, "R11 err1", {30'd0, s_hready, s_hresp}, 32'h1);
    @(negedge clk);
    #1 chk(s_hready && s_hresp && f_htrans == 2'b00, "R11 err2 refused held",
           {28'd0, s_hready, s_hresp, f_htrans}, 32'hC);
    @(negedge clk);
    s_haddr = 32'h00FF_D010; s_hprot = 2'b11;
    #1 chk(!s_hready && s_hresp, "R11 second err1", {30'd0, s_hready, s_hresp}, 32'h1);
    @(negedge clk);
    #1 chk(s_hready && s_hresp && f_htrans == 2'b10, "R11 permitted in err2",
           {28'd0, s_hready, s_hresp, f_htrans}, 32'hE);
    @(negedge clk);
    s_htrans = 2'b00;
    #1 chk(s_hready && !s_hresp, "R11 data phase", {30'd0, s_hready, s_hresp}, 32'h2);

    // R10: flash wait and error mirrored
    @(negedge clk);
    s_haddr = 32'h0000_4000; s_hprot = 2'b11; s_htrans = 2'b10;
    @(negedge clk);
    s_htrans = 2'b00; f_hreadyout = 1'b0; f_hresp = 1'b1;
    #1 chk(!s_hready && s_hresp, "R10 flash err1", {30'd0, s_hready, s_hresp}, 32'h1);
    @(negedge clk);
    f_hreadyout = 1'b1;
    #1 chk(s_hready && s_hresp, "R10 flash err2", {30'd0, s_hready, s_hresp}, 32'h3);
    @(negedge clk);
    f_hresp = 1'b0;
    #1 chk(s_hready && !s_hresp, "R10 idle", {30'd0, s_hready, s_hresp}, 32'h2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule